// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block runs the digital half of a successive-approximation converter. It owns a trial code register that feeds an external DAC. A comparator then tells the block whether the DAC output is above the analog input. The block sees the analog side only through that single greater-than flag.

While idle it raises `ready`. When `start` arrives it loads a trial code with only the top bit set. It then spends one clock on each bit, from the top bit down to bit 0. In each of those clocks it decides whether to keep or drop the bit under test and, in the same clock, raises the next lower bit. After the bit-0 clock it returns to idle, and the converted code stays on `result` until the next start.

Top module: `sarc_top`

## Requirements
- R1: A synchronous active-high `rst` leaves the block idle, with `ready` = 1 and `result` = 0 after the clock edge.
- R2: While idle, `ready` is 1 and `result` holds its value for as long as `start` stays low.
- R3: `start` = 1 while idle is accepted at the clock edge. After that edge, `result` has only bit WIDTH-1 set (binary 1000 for WIDTH = 4) and `ready` is 0.
- R4: After a start is accepted, `ready` stays 0 for exactly WIDTH cycles, one for each bit from WIDTH-1 down to 0. It returns to 1 after the bit-0 cycle.
- R5: In the cycle that tests bit n, `gt` = 1 clears bit n of `result` and `gt` = 0 keeps it.
- R6: In the cycle that tests bit n with n > 0, bit n-1 of `result` is set at the same edge, whatever `gt` is. In the bit-0 cycle no lower bit is set.
- R7: With a comparator that raises `gt` whenever `result` exceeds a target code, `result` equals the target once `ready` returns, WIDTH+1 edges after start was sampled.
- R8: `start` has no effect while a conversion is in progress.
- R9: `gt` has no effect while idle.
- R10: `rst` in the middle of a conversion abandons it and gives the same idle state as R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a conversion, sampled while idle |
| gt | input | 1 | Comparator flag: DAC output above analog input |
| ready | output | 1 | High while idle |
| result | output | WIDTH | Trial code while converting, final code while idle |

## Verification
The bench builds the block with the default WIDTH = 4. At that width every target code from 0 to 15 is within reach, including the all-zero and all-one extremes, where the comparator answers the same way on every bit. The bench follows the expected trial code edge by edge through each conversion. This makes every keep-or-clear decision and every lower-bit set visible, and it separately drives `gt` and `start` in the phases where they must be ignored.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic loadInit;   // load top bit, clear the rest
    logic clearCur;   // drop the bit currently under test
    logic setNext;    // raise the bit just below the one under test
  } sarcStrobe_t;
endpackage

// File: rtl/sarc_ctrl.sv
module sarc_ctrl
  import sarc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             gt,
  output logic             ready,
  output sarcStrobe_t      strobe,
  output logic [WIDTH-1:0] testPos
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic             waitQ;
  logic [WIDTH-1:0] testQ;   // one-hot: one state per bit under test
  logic             waitD;
  logic [WIDTH-1:0] testD;
  logic             testing;

  assign testing = |testQ;

  // Mealy strobes: valid only when state and condition hold together
  always_comb begin
    strobe.loadInit = waitQ & start;
    strobe.clearCur = testing & gt;
    strobe.setNext  = testing & ~testQ[0];
  end

  always_comb begin
    testD = strobe.loadInit ? TOP_BIT : (testQ >> 1);
    waitD = (waitQ & ~start) | testQ[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waitQ <= 1'b1;
      testQ <= '0;
    end else begin
      waitQ <= waitD;
      testQ <= testD;
    end
  end

  assign ready   = waitQ;
  assign testPos = testQ;

  if (MSB < 1) begin : g_width_check
    initial $error("sarc_ctrl: WIDTH must be at least 2");
  end
endmodule

// File: rtl/sarc_dpath.sv
module sarc_dpath
  import sarc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  sarcStrobe_t      strobe,
  input  logic [WIDTH-1:0] testPos,
  output logic [WIDTH-1:0] code
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] codeQ;
  logic [WIDTH-1:0] codeD;
  logic [WIDTH-1:0] clearMask;
  logic [WIDTH-1:0] setMask;

  // Clear and set always touch different bits, so no ordering is implied
  assign clearMask = testPos & {WIDTH{strobe.clearCur}};
  assign setMask   = (testPos >> 1) & {WIDTH{strobe.setNext}};

  always_comb begin
    if (strobe.loadInit) codeD = TOP_BIT;
    else                 codeD = (codeQ & ~clearMask) | setMask;
  end

  always_ff @(posedge clk) begin
    if (rst) codeQ <= '0;
    else     codeQ <= codeD;
  end

  assign code = codeQ;
endmodule

// File: rtl/sarc_top.sv
module sarc_top
  import sarc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             gt,
  output logic             ready,
  output logic [WIDTH-1:0] result
);
  sarcStrobe_t      strobe;
  logic [WIDTH-1:0] testPos;

  sarc_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .gt     (gt),
    .ready  (ready),
    .strobe (strobe),
    .testPos(testPos)
  );

  sarc_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .testPos(testPos),
    .code   (result)
  );
endmodule

// File: rtl/sarc_chk.sv
module sarc_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             gt,
  input logic             ready,
  input logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  int unsigned busyCnt;
  always_ff @(posedge clk) begin
    if (rst || ready) busyCnt <= 0;
    else              busyCnt <= busyCnt + 1;
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> (ready && $stable(result)));

  assert_start_load_R3: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> (!ready && result == TOP_BIT));

  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (busyCnt < WIDTH));

  assert_busy_end_R4: assert property (@(posedge clk) disable iff (rst)
    (!ready && busyCnt == WIDTH - 1) |=> ready);

  assert_gt_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (!ready && gt) |=> (result < $past(result)));

  assert_keep_rises_R6: assert property (@(posedge clk) disable iff (rst)
    (!ready && !gt) |=> (result >= $past(result)));

  assert_two_bits_max_R6: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ($countones(result ^ $past(result)) <= 2));
endmodule

bind sarc_top sarc_chk #(.WIDTH(WIDTH)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .gt    (gt),
  .ready (ready),
  .result(result)
);

// File: tb/sarc_top_tb_top.sv
`timescale 1ns/1ps
module sarc_top_tb_top;
  localparam int W = 4;
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};
  localparam int NVEC = 8;
  // {target, expected final code}
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    8'h00, 8'hFF, 8'h55, 8'hAA, 8'h88, 8'h77, 8'h11, 8'hEE
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic gtOvr = 1'b0;
  logic gtVal = 1'b0;
  logic [W-1:0] target = '0;
  logic gt;
  logic ready;
  logic [W-1:0] result;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Comparator model: DAC output above the analog target
  assign gt = gtOvr ? gtVal : (result > target);

  sarc_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .gt(gt),
    .ready(ready), .result(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  // One conversion, tracking the expected trial code each edge
  task automatic convert(input logic [W-1:0] tgt, input logic [W-1:0] expFinal,
                         input bit holdStart);
    logic [W-1:0] expCode;
    target = tgt;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    if (!holdStart) start = 1'b0;
    check(result == TOP, "R3 load", int'(result), int'(TOP));
    check(ready == 1'b0, "R3 busy", int'(ready), 0);
    expCode = TOP;
    for (int b = W - 1; b >= 0; b--) begin
      if (expCode > tgt) expCode[b] = 1'b0;
      if (b > 0) expCode[b-1] = 1'b1;
      if (b == 0) start = 1'b0;
      @(negedge clk);
      check(result == expCode, "R5 R6 step", int'(result), int'(expCode));
      check(ready == (b == 0), "R4 ready", int'(ready), int'(b == 0));
    end
    check(result == expFinal, holdStart ? "R8 final" : "R7 final",
          int'(result), int'(expFinal));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(ready == 1'b1, "R1 ready", int'(ready), 1);
    check(result == '0, "R1 result", int'(result), 0);

    for (int i = 0; i < NVEC; i++)
      convert(VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0);

    // R2: idle hold without start
    repeat (4) @(negedge clk);
    check(ready == 1'b1, "R2 ready", int'(ready), 1);
    check(result == VEC[NVEC-1][W-1:0], "R2 hold", int'(result), int'(VEC[NVEC-1][W-1:0]));

    // R9: gt forced either way while idle
    gtOvr = 1'b1; gtVal = 1'b1;
    repeat (3) @(negedge clk);
    check(result == VEC[NVEC-1][W-1:0], "R9 gt high", int'(result), int'(VEC[NVEC-1][W-1:0]));
    gtVal = 1'b0;
    repeat (3) @(negedge clk);
    check(result == VEC[NVEC-1][W-1:0], "R9 gt low", int'(result), int'(VEC[NVEC-1][W-1:0]));
    check(ready == 1'b1, "R9 ready", int'(ready), 1);
    gtOvr = 1'b0;

    // R8: start held high through the conversion
    convert(4'd9, 4'd9, 1'b1);
    convert(4'd6, 4'd6, 1'b1);

    // R7 exhaustive sweep of targets
    for (int t = 0; t < (1 << W); t++)
      convert(W'(t), W'(t), 1'b0);

    // R10: reset mid-conversion
    target = 4'd3;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(ready == 1'b1, "R10 ready", int'(ready), 1);
    check(result == '0, "R10 result", int'(result), 0);
    @(negedge clk);
    check(ready == 1'b1, "R10 stays idle", int'(ready), 1);
    convert(4'd12, 4'd12, 1'b0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule